// File: doc/BRIEF.md
# Double-Buffered Sample Fetcher

This block feeds an audio serializer with samples it reads from memory. The host describes two buffers, each with a base word address and a length in memory words. While `run` is high the fetcher walks the current buffer one word at a time over a simple read port. When it has issued the last word of that buffer it moves straight to the other buffer and raises a refill request for the one it just finished. The host answers a refill request by writing a fresh descriptor for that buffer. The two buffers keep alternating in this way for as long as the host keeps them filled.

Read responses go into a small FIFO. A read is issued only when the words already in the FIFO plus the reads still in flight leave room, so the FIFO can never overflow. On the far side of the FIFO an unpacker presents each word as one 32-bit sample, or as two 16-bit samples. If the fetcher finishes a buffer and the other buffer holds no descriptor, it stops reading and latches an underrun flag.

Top module: `sample_dma_fetcher`

## Requirements
- R1: A cycle with `cfg_we` high stores `cfg_base` and `cfg_len` (length of at least 1 word) as the descriptor of buffer `cfg_sel` (0 or 1), marks that buffer loaded, and clears `refill_req[cfg_sel]` from the next cycle on.
- R2: While `run` is high, reads go out at addresses base, base+1, ..., base+len-1 of the current buffer in that order. Buffer 0 is the first one used after `run` rises.
- R3: After the last read of a buffer is accepted, the next read address is the other buffer's base. If that buffer is loaded, or is being written in the same cycle, the read is requested in the very next cycle.
- R4: `refill_req[b]` goes high in the cycle after the last read of buffer b is accepted. It stays high until the host writes buffer b.
- R5: If the other buffer is not loaded when a buffer ends, `underrun` goes high in the next cycle and no further reads are issued. `underrun` stays high until `run` goes low. Taking `run` low clears it and returns the fetcher to buffer 0, offset 0.
- R6: With `wide`=1 each memory word is one sample. With `wide`=0 each word gives two samples: bits [15:0] first, then bits [31:16], each zero-extended in `smp_data`.
- R7: The number of words in the FIFO plus the number of accepted reads still waiting for a response never exceeds FIFO_DEPTH. Responses come back in order, one for each accepted read.
- R8: While `smp_valid` is high and `smp_ready` is low, `smp_valid` and `smp_data` stay unchanged.
- R9: After reset `rd_req`, `smp_valid`, `refill_req` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Fetching enabled; low clears underrun and restarts at buffer 0 |
| wide | input | 1 | 1: 32-bit samples, 0: two 16-bit samples per word |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 1 | Buffer being written |
| cfg_base | input | ADDR_W | Base word address |
| cfg_len | input | LEN_W | Length in words |
| refill_req | output | 2 | Per-buffer request for a new descriptor |
| underrun | output | 1 | Sticky: next buffer was missing |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read word address |
| rd_ready | input | 1 | Memory accepts the request this cycle |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data |
| smp_valid | output | 1 | Sample available |
| smp_data | output | 32 | Sample |
| smp_ready | input | 1 | Serializer takes the sample |

## Verification
A read is accepted at the clock edge where `rd_req` and `rd_ready` are both high. The refill request and the underrun flag of a buffer change at that same edge. With the bench memory, which answers one cycle after it accepts a read, the word is offered as a sample one cycle after its response. The bench drives inputs at rising edges and samples every output at the following falling edge. It logs each read and sample handshake in the cycle it occurs, and compares the cycle numbers of consecutive reads to confirm that a buffer switch adds no gap. The flag and count checks are made only after a fixed number of settling cycles, once all the expected traffic must have finished.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int SMP_W  = 32;
    localparam int HALF_W = 16;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_id_e;
endpackage

// File: rtl/sdf_fifo.sv
module sdf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             nonempty,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = bump(st_q.wp);
        if (pop)  st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= wdata;
    end

    assign head     = mem[st_q.rp];
    assign nonempty = (st_q.cnt != '0);
    assign count    = st_q.cnt;
endmodule

// File: rtl/sdf_unpack.sv
module sdf_unpack
    import sdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_word,
    output logic             in_pop,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data,
    input  logic             out_ready
);
    typedef struct packed {
        logic upper;
    } unpack_st_t;

    unpack_st_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d      = st_q;
        fire      = in_valid && out_ready;
        out_valid = in_valid;
        if (wide) begin
            out_data = in_word;
            in_pop   = fire;
            st_d.upper = 1'b0;
        end else begin
            out_data = {{(SMP_W - HALF_W){1'b0}},
                        st_q.upper ? in_word[SMP_W-1:HALF_W] : in_word[HALF_W-1:0]};
            in_pop   = fire && st_q.upper;
            if (fire) st_d.upper = ~st_q.upper;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sample_dma_fetcher.sv
module sample_dma_fetcher
    import sdf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wide,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic [1:0]        refill_req,
    output logic              underrun,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rd_rvalid,
    input  logic [SMP_W-1:0]  rd_rdata,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    input  logic              smp_ready
);
    typedef struct packed {
        buf_id_e                  cur;
        logic [LEN_W-1:0]         off;
        logic [1:0]               loaded;
        logic [1:0]               refill;
        logic                     under;
        logic [CNT_W-1:0]         outst;
        logic [1:0][ADDR_W-1:0]   base;
        logic [1:0][LEN_W-1:0]    len;
    } walk_st_t;

    walk_st_t         st_d, st_q;
    logic [CNT_W-1:0] fifo_cnt;
    logic [CNT_W-1:0] outst_cnt;
    logic             credit_ok;
    logic             accept;
    logic             at_last;
    logic             next_ready;
    buf_id_e          other;
    logic             head_valid;
    logic             head_pop;
    logic [SMP_W-1:0] head_word;

    always_comb begin
        st_d       = st_q;
        other      = buf_id_e'(~st_q.cur);
        credit_ok  = ({1'b0, fifo_cnt} + {1'b0, st_q.outst}) < (CNT_W + 1)'(FIFO_DEPTH);
        rd_req     = run && !st_q.under && st_q.loaded[st_q.cur] && credit_ok;
        rd_addr    = st_q.base[st_q.cur] + ADDR_W'(st_q.off);
        accept     = rd_req && rd_ready;
        at_last    = (st_q.off == st_q.len[st_q.cur] - 1'b1);
        next_ready = st_q.loaded[other] || (cfg_we && (cfg_sel == other));

        case ({accept, rd_rvalid})
            2'b10:   st_d.outst = st_q.outst + 1'b1;
            2'b01:   st_d.outst = st_q.outst - 1'b1;
            default: st_d.outst = st_q.outst;
        endcase

        if (!run) begin
            st_d.cur   = BUF_A;
            st_d.off   = '0;
            st_d.under = 1'b0;
        end else if (accept) begin
            if (at_last) begin
                st_d.off                 = '0;
                st_d.loaded[st_q.cur]    = 1'b0;
                st_d.refill[st_q.cur]    = 1'b1;
                st_d.cur                 = other;
                if (!next_ready) st_d.under = 1'b1;
            end else begin
                st_d.off = st_q.off + 1'b1;
            end
        end

        if (cfg_we) begin
            st_d.base[cfg_sel]   = cfg_base;
            st_d.len[cfg_sel]    = cfg_len;
            st_d.loaded[cfg_sel] = 1'b1;
            st_d.refill[cfg_sel] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign refill_req = st_q.refill;
    assign underrun   = st_q.under;
    assign outst_cnt  = st_q.outst;

    sdf_fifo #(
        .WIDTH (SMP_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rd_rvalid),
        .wdata    (rd_rdata),
        .pop      (head_pop),
        .head     (head_word),
        .nonempty (head_valid),
        .count    (fifo_cnt)
    );

    sdf_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (wide),
        .in_valid  (head_valid),
        .in_word   (head_word),
        .in_pop    (head_pop),
        .out_valid (smp_valid),
        .out_data  (smp_data),
        .out_ready (smp_ready)
    );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cfg_we,
    input logic             cfg_sel,
    input logic [1:0]       refill_req,
    input logic             underrun,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic [31:0]      smp_data,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic [CNT_W-1:0] outst
);
    a_r1_write_clears_a: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> !refill_req[0]);

    a_r1_write_clears_b: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> !refill_req[1]);

    a_r4_refill_holds_a: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req[0] && !(cfg_we && !cfg_sel)) |=> refill_req[0]);

    a_r4_refill_holds_b: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req[1] && !(cfg_we && cfg_sel)) |=> refill_req[1]);

    a_r5_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && run) |=> underrun);

    a_r7_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, fifo_cnt} + {1'b0, outst}) <= (CNT_W + 1)'(FIFO_DEPTH));

    a_r8_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
endmodule

bind sample_dma_fetcher sdf_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_sdf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .refill_req (refill_req),
    .underrun   (underrun),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_data   (smp_data),
    .fifo_cnt   (fifo_cnt),
    .outst      (outst_cnt)
);

// File: tb/sample_dma_fetcher_test.sv
`timescale 1ns/1ps
module sample_dma_fetcher_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wide = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_len = '0;
    logic [1:0]  refill_req;
    logic        underrun;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ready = 1'b1;
    logic        rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic        smp_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    int smp_cnt = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int smp_mode = 0;
    int exp_rd_n = 0;
    int exp_smp_n = 0;
    logic [15:0] exp_addr [16];
    logic [31:0] exp_smp [32];
    int rd_cyc [16];
    logic        hold_prev = 1'b0;
    logic [31:0] data_prev = '0;

    always #2.5 clk = ~clk;

    sample_dma_fetcher uut (
        .clk(clk), .rst_n(rst_n), .run(run), .wide(wide),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .refill_req(refill_req), .underrun(underrun),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a ^ 16'hA5A5, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] base, input logic [7:0] len);
        @(posedge clk);
        cfg_we   <= 1'b1;
        cfg_sel  <= sel;
        cfg_base <= base;
        cfg_len  <= len;
        @(posedge clk);
        cfg_we   <= 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // memory model (one cycle latency) and ready patterns
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            rd_rvalid <= rd_req && rd_ready;
            rd_rdata  <= mem_word(rd_addr);
            rd_ready  <= (rdy_mode == 1) ? ~rd_ready : 1'b1;
            smp_ready <= (smp_mode == 1) ? 1'b1 : ((smp_mode == 2) ? ~smp_ready : 1'b0);
        end
    end

    // monitor: reads, samples, hold stability
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_req && rd_ready) begin
                if (rd_cnt < exp_rd_n)
                    check(rd_addr == exp_addr[rd_cnt], "R2", "read address", rd_addr, exp_addr[rd_cnt]);
                else
                    check(1'b0, "R5", "unexpected read", rd_addr, 0);
                if (rd_cnt < 16) rd_cyc[rd_cnt] = cyc;
                rd_cnt++;
            end
            if (rst_n && hold_prev && smp_valid)
                check(smp_data == data_prev, "R8", "held sample", smp_data, data_prev);
            if (rst_n && smp_valid && smp_ready) begin
                if (smp_cnt < exp_smp_n)
                    check(smp_data == exp_smp[smp_cnt], "R6", "sample", smp_data, exp_smp[smp_cnt]);
                else
                    check(1'b0, "R6", "unexpected sample", smp_data, 0);
                smp_cnt++;
            end
            hold_prev = rst_n && smp_valid && !smp_ready;
            data_prev = smp_data;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_req == 1'b0, "R9", "rd_req after reset", rd_req, 0);
        check(smp_valid == 1'b0, "R9", "smp_valid after reset", smp_valid, 0);
        check(refill_req == 2'b00, "R9", "refill_req after reset", refill_req, 0);
        check(underrun == 1'b0, "R9", "underrun after reset", underrun, 0);
        @(posedge clk);
        rst_n <= 1'b1;

        // scenario 1: 32-bit samples, refill of buffer 0 only
        exp_addr[0] = 16'h100; exp_addr[1] = 16'h101; exp_addr[2] = 16'h102;
        exp_addr[3] = 16'h200; exp_addr[4] = 16'h201;
        exp_addr[5] = 16'h300; exp_addr[6] = 16'h301;
        exp_rd_n = 7;
        for (int i = 0; i < 7; i++) exp_smp[i] = mem_word(exp_addr[i]);
        exp_smp_n = 7;
        wide = 1'b1;
        smp_mode = 1;
        rdy_mode = 0;
        cfg_write(1'b0, 16'h100, 8'd3);
        cfg_write(1'b1, 16'h200, 8'd2);
        @(negedge clk);
        check(refill_req == 2'b00, "R1", "refill after load", refill_req, 0);
        check(rd_req == 1'b0, "R2", "no read before run", rd_req, 0);
        @(posedge clk);
        run <= 1'b1;
        wait (refill_req[0]);
        cfg_write(1'b0, 16'h300, 8'd2);
        wait (underrun);
        repeat (20) @(negedge clk);
        check(rd_cnt == 7, "R5", "reads before stop", rd_cnt, 7);
        check(smp_cnt == 7, "R6", "wide sample count", smp_cnt, 7);
        check(rd_cyc[3] == rd_cyc[2] + 1, "R3", "switch gap 0->1", rd_cyc[3] - rd_cyc[2], 1);
        check(rd_cyc[5] == rd_cyc[4] + 1, "R3", "switch gap 1->0 with same-cycle write",
              rd_cyc[5] - rd_cyc[4], 1);
        check(refill_req == 2'b11, "R4", "refill flags after drain", refill_req, 3);
        check(underrun == 1'b1, "R5", "underrun latched", underrun, 1);

        @(posedge clk);
        run <= 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(underrun == 1'b0, "R5", "underrun cleared by run low", underrun, 0);

        // scenario 2: 16-bit samples, backpressure, no refills
        rd_cnt = 0;
        smp_cnt = 0;
        for (int i = 0; i < 4; i++) exp_addr[i] = 16'h040 + 16'(i);
        exp_addr[4] = 16'h050; exp_addr[5] = 16'h051;
        exp_rd_n = 6;
        for (int i = 0; i < 6; i++) begin
            exp_smp[2*i]   = {16'h0, mem_word(exp_addr[i])[15:0]};
            exp_smp[2*i+1] = {16'h0, mem_word(exp_addr[i])[31:16]};
        end
        exp_smp_n = 12;
        wide = 1'b0;
        smp_mode = 0;
        rdy_mode = 1;
        cfg_write(1'b0, 16'h040, 8'd4);
        cfg_write(1'b1, 16'h050, 8'd2);
        @(negedge clk);
        check(refill_req == 2'b00, "R1", "refill cleared by writes", refill_req, 0);
        @(posedge clk);
        run <= 1'b1;
        repeat (30) @(negedge clk);
        check(rd_cnt == 4, "R7", "reads limited by FIFO space", rd_cnt, 4);
        check(smp_cnt == 0, "R8", "no sample taken while not ready", smp_cnt, 0);
        smp_mode = 2;
        wait (underrun);
        repeat (40) @(negedge clk);
        check(rd_cnt == 6, "R2", "reads in scenario 2", rd_cnt, 6);
        check(smp_cnt == 12, "R6", "half sample count", smp_cnt, 12);
        check(refill_req == 2'b11, "R4", "refill flags scenario 2", refill_req, 3);
        check(underrun == 1'b1, "R5", "underrun scenario 2", underrun, 1);
        summary();
    end
endmodule